// File: doc/BRIEF.md
# Multi-lane ADC serial frame capture

This block receives conversion results from a converter that has no SPI port. Instead it drives a frame marker, a bit clock of up to 20 MHz and a set of serial data lanes. Capture runs entirely in the bit clock domain. Each frame is assembled into one wide word. The finished word is then handed to the system clock domain, where it appears together with a single-cycle valid pulse.

There are two lane modes. In serial mode the whole 96-bit frame arrives on lane 0, and the other lanes are ignored. In split mode lanes 0, 1 and 2 each carry one 32-bit word at the same time. The mode input is taken only at the first bit of a frame. A frame marker that arrives before the current frame is complete abandons the partial frame, starts a new one and raises a sticky error flag.

Top module: `adc_lane_capture`

## Requirements
- R1: After reset, `sample_valid` is 0, `frame_err` is 0 and `sample_data` is all zeros.
- R2: Bits are sampled on the falling edge of `bit_clk`, most significant bit first. The edge at which `frame_mark` is 1 samples the first bit. In serial mode (`split_mode`=0) the first bit lands in `sample_data[95]` and the 96th bit in `sample_data[0]`; lanes 1 and 2 have no effect.
- R3: In split mode (`split_mode`=1) each frame is 32 bits long. Lane k fills `sample_data[95-32k : 64-32k]`, most significant bit first.
- R4: Each completed frame produces exactly one `sample_valid` pulse, one `sys_clk` cycle wide. The pulse comes with the frame's word on `sample_data`.
- R5: Once a frame is complete, further `bit_clk` edges with `frame_mark` at 0 are ignored: no extra pulse, and no change to `sample_data`.
- R6: A `frame_mark` that arrives during an incomplete frame discards the partial frame and starts a new one at that edge. It also sets `frame_err`, which stays 1 until reset.
- R7: `split_mode` is sampled only on the edge that carries `frame_mark`. Changing it during a frame does not change that frame's length or bit placement.
- R8: `sample_data` holds its value in every cycle in which `sample_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Data clock from the converter; bits sampled on its falling edge |
| bit_rst_n | input | 1 | Asynchronous active-low reset, bit clock domain |
| frame_mark | input | 1 | Active-high marker on the first bit of a frame |
| lane_in | input | LANES (3) | Serial data lanes, lane 0 in bit 0 |
| split_mode | input | 1 | 0: all bits on lane 0; 1: one word per lane |
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset, system domain |
| sample_data | output | LANES*WORD_W (96) | Last completed frame |
| sample_valid | output | 1 | One-cycle pulse per new frame |
| frame_err | output | 1 | Sticky flag: a frame was cut short by a new marker |

## Verification
The hardest case to reach from the ports is a frame marker that lands in the middle of a frame. The bench reaches it by stopping a frame after 20 bits and starting a complete frame right away. It then checks three things: only the second word comes out, exactly one pulse is seen, and the error flag stays set through later clean frames. A mode change during a frame is reached the same way, by flipping `split_mode` after the marker edge of a split frame. Trailing clocks after a complete frame are driven with non-zero lane data, so that any spurious shift would be visible on the outputs.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic {
    LANE_SERIAL = 1'b0,
    LANE_SPLIT  = 1'b1
  } lane_mode_e;

  // Bits carried per lane in one frame, for the given lane mode.
  function automatic int unsigned frame_bits(input lane_mode_e mode,
                                             input int unsigned lanes,
                                             input int unsigned word_w);
    return (mode == LANE_SPLIT) ? word_w : lanes * word_w;
  endfunction

  // Index of the top bit of lane k's field in the assembled frame.
  function automatic int unsigned lane_top(input int unsigned k,
                                           input int unsigned lanes,
                                           input int unsigned word_w);
    return lanes * word_w - 1 - k * word_w;
  endfunction

endpackage

// File: rtl/adc_lane_shifter.sv
module adc_lane_shifter
  import adc_cap_pkg::*;
#(
  parameter int unsigned LANES  = 3,
  parameter int unsigned WORD_W = 32
) (
  input  logic                        bit_clk,
  input  logic                        bit_rst_n,
  input  logic                        frame_mark,
  input  logic [LANES-1:0]            lane_in,
  input  logic                        split_mode,
  output logic [LANES*WORD_W-1:0]     hold_word,
  output logic                        done_tgl,
  output logic                        err_sticky,
  output logic                        cap_busy,
  output logic [$clog2(LANES*WORD_W+1)-1:0] bit_cnt,
  output lane_mode_e                  mode_lat,
  output logic                        ev_start,
  output logic                        ev_restart,
  output logic                        ev_done
);

  localparam int unsigned FRAME_W = LANES * WORD_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] shift_serial;
  logic [FRAME_W-1:0] shift_split;
  logic [FRAME_W-1:0] shift_next;
  lane_mode_e         mode_sel;
  lane_mode_e         mode_in;
  logic               advance;
  logic [CNT_W-1:0]   last_idx;

  assign mode_in = lane_mode_e'(split_mode);

  // Serial mode: the whole frame is one shift chain fed by lane 0.
  assign shift_serial = {frame_q[FRAME_W-2:0], lane_in[0]};

  // Split mode: one independent chain per lane.
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int unsigned HI = lane_top(k, LANES, WORD_W);
      assign shift_split[HI -: WORD_W] = {frame_q[HI-1 -: WORD_W-1], lane_in[k]};
    end
  endgenerate

  // The marker edge uses the incoming mode; later edges use the latched one.
  assign mode_sel   = frame_mark ? mode_in : mode_lat;
  assign shift_next = (mode_sel == LANE_SPLIT) ? shift_split : shift_serial;

  assign ev_start   = frame_mark;
  assign ev_restart = frame_mark && cap_busy;
  assign advance    = cap_busy && !frame_mark;
  assign last_idx   = CNT_W'(frame_bits(mode_lat, LANES, WORD_W) - 1);
  assign ev_done    = advance && (bit_cnt == last_idx);

  always_ff @(negedge bit_clk or negedge bit_rst_n) begin
    if (!bit_rst_n) begin
      frame_q    <= '0;
      hold_word  <= '0;
      done_tgl   <= 1'b0;
      err_sticky <= 1'b0;
      cap_busy   <= 1'b0;
      bit_cnt    <= '0;
      mode_lat   <= LANE_SERIAL;
    end else if (ev_start) begin
      frame_q  <= shift_next;
      cap_busy <= 1'b1;
      bit_cnt  <= CNT_W'(1);
      mode_lat <= mode_in;
      if (ev_restart) err_sticky <= 1'b1;
    end else if (advance) begin
      frame_q <= shift_next;
      bit_cnt <= bit_cnt + CNT_W'(1);
      if (ev_done) begin
        cap_busy  <= 1'b0;
        hold_word <= shift_next;
        done_tgl  <= ~done_tgl;
      end
    end
  end

endmodule

// File: rtl/adc_toggle_xfer.sv
module adc_toggle_xfer #(
  parameter int unsigned W      = 96,
  parameter int unsigned STAGES = 2
) (
  input  logic         sys_clk,
  input  logic         sys_rst_n,
  input  logic         tgl_in,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] data_out,
  output logic         valid_out,
  output logic         ev_arrive
);

  logic [STAGES-1:0] sync_q;
  logic              seen_q;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tgl_in};
    end
  end

  // A new word has arrived whenever the synchronised toggle changes level.
  assign ev_arrive = sync_q[STAGES-1] ^ seen_q;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      seen_q    <= 1'b0;
      data_out  <= '0;
      valid_out <= 1'b0;
    end else begin
      seen_q    <= sync_q[STAGES-1];
      valid_out <= ev_arrive;
      if (ev_arrive) data_out <= data_in;
    end
  end

endmodule

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic sys_clk,
  input  logic sys_rst_n,
  input  logic bit_in,
  output logic bit_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) chain_q <= '0;
    else            chain_q <= {chain_q[STAGES-2:0], bit_in};
  end

  assign bit_out = chain_q[STAGES-1];

endmodule

// File: rtl/adc_lane_capture.sv
module adc_lane_capture
  import adc_cap_pkg::*;
#(
  parameter int unsigned LANES       = 3,
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    bit_clk,
  input  logic                    bit_rst_n,
  input  logic                    frame_mark,
  input  logic [LANES-1:0]        lane_in,
  input  logic                    split_mode,
  input  logic                    sys_clk,
  input  logic                    sys_rst_n,
  output logic [LANES*WORD_W-1:0] sample_data,
  output logic                    sample_valid,
  output logic                    frame_err
);

  localparam int unsigned FRAME_W = LANES * WORD_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  // Named internal events, brought out for the checker.
  logic [FRAME_W-1:0] hold_word;
  logic               done_tgl;
  logic               err_sticky;
  logic               cap_busy;
  logic [CNT_W-1:0]   bit_cnt;
  lane_mode_e         mode_lat;
  logic               ev_start;
  logic               ev_restart;
  logic               ev_done;
  logic               ev_arrive;

  adc_lane_shifter #(.LANES(LANES), .WORD_W(WORD_W)) u_shift (
    .bit_clk    (bit_clk),
    .bit_rst_n  (bit_rst_n),
    .frame_mark (frame_mark),
    .lane_in    (lane_in),
    .split_mode (split_mode),
    .hold_word  (hold_word),
    .done_tgl   (done_tgl),
    .err_sticky (err_sticky),
    .cap_busy   (cap_busy),
    .bit_cnt    (bit_cnt),
    .mode_lat   (mode_lat),
    .ev_start   (ev_start),
    .ev_restart (ev_restart),
    .ev_done    (ev_done)
  );

  adc_toggle_xfer #(.W(FRAME_W), .STAGES(SYNC_STAGES)) u_xfer (
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n),
    .tgl_in    (done_tgl),
    .data_in   (hold_word),
    .data_out  (sample_data),
    .valid_out (sample_valid),
    .ev_arrive (ev_arrive)
  );

  adc_bit_sync #(.STAGES(SYNC_STAGES)) u_err_sync (
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n),
    .bit_in    (err_sticky),
    .bit_out   (frame_err)
  );

endmodule

// File: rtl/adc_lane_capture_chk.sv
module adc_lane_capture_chk
  import adc_cap_pkg::*;
#(
  parameter int unsigned LANES  = 3,
  parameter int unsigned WORD_W = 32
) (
  input logic                                bit_clk,
  input logic                                bit_rst_n,
  input logic                                frame_mark,
  input logic                                sys_clk,
  input logic                                sys_rst_n,
  input logic [LANES*WORD_W-1:0]             sample_data,
  input logic                                sample_valid,
  input logic                                frame_err,
  input logic                                err_sticky,
  input logic                                cap_busy,
  input logic [$clog2(LANES*WORD_W+1)-1:0]   bit_cnt,
  input lane_mode_e                          mode_lat,
  input logic                                ev_restart
);

  // R5: while a frame runs, the count never reaches the frame length.
  assert_count_bound_R5: assert property (@(negedge bit_clk) disable iff (!bit_rst_n)
    cap_busy |-> (int'(bit_cnt) < int'(frame_bits(mode_lat, LANES, WORD_W))));

  // R6: a restarted frame leaves the error flag set.
  assert_restart_flags_R6: assert property (@(negedge bit_clk) disable iff (!bit_rst_n)
    ev_restart |=> err_sticky);

  // R7: the latched mode does not move inside a frame.
  assert_mode_hold_R7: assert property (@(negedge bit_clk) disable iff (!bit_rst_n)
    (cap_busy && !frame_mark) |=> $stable(mode_lat));

  // R4: the valid pulse is one cycle wide.
  assert_valid_single_R4: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    sample_valid |=> !sample_valid);

  // R8: the output word only changes along with a valid pulse.
  assert_data_hold_R8: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !sample_valid |-> $stable(sample_data));

  // R6: the error flag never clears outside reset.
  assert_err_sticky_R6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    frame_err |=> frame_err);

endmodule

bind adc_lane_capture adc_lane_capture_chk #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (
  .bit_clk      (bit_clk),
  .bit_rst_n    (bit_rst_n),
  .frame_mark   (frame_mark),
  .sys_clk      (sys_clk),
  .sys_rst_n    (sys_rst_n),
  .sample_data  (sample_data),
  .sample_valid (sample_valid),
  .frame_err    (frame_err),
  .err_sticky   (err_sticky),
  .cap_busy     (cap_busy),
  .bit_cnt      (bit_cnt),
  .mode_lat     (mode_lat),
  .ev_restart   (ev_restart)
);

// File: tb/adc_lane_capture_tb.sv
module adc_lane_capture_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BIT_HALF   = 25;
  localparam int SETTLE     = CLK_PERIOD * 12;

  typedef struct packed {
    logic        split;
    logic [95:0] word;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 96'h8000_0000_0000_0000_0000_0001},
    '{1'b0, 96'hDEAD_BEEF_0123_4567_89AB_CDEF},
    '{1'b1, 96'hA5A5_A5A5_0000_0000_FFFF_FFFF},
    '{1'b1, 96'h1234_5678_9ABC_DEF0_0F1E_2D3C},
    '{1'b0, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF},
    '{1'b1, 96'h8000_0001_7FFF_FFFE_C003_3C00}
  };

  logic        bit_clk = 1'b1;
  logic        bit_rst_n = 1'b0;
  logic        frame_mark = 1'b0;
  logic [2:0]  lane_in = '0;
  logic        split_mode = 1'b0;
  logic        sys_clk = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic [95:0] sample_data;
  logic        sample_valid;
  logic        frame_err;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  int wide_pulses = 0;
  logic prev_valid = 1'b0;
  logic finished = 1'b0;

  adc_lane_capture u_dut (
    .bit_clk      (bit_clk),
    .bit_rst_n    (bit_rst_n),
    .frame_mark   (frame_mark),
    .lane_in      (lane_in),
    .split_mode   (split_mode),
    .sys_clk      (sys_clk),
    .sys_rst_n    (sys_rst_n),
    .sample_data  (sample_data),
    .sample_valid (sample_valid),
    .frame_err    (frame_err)
  );

  always #(CLK_PERIOD/2) sys_clk = ~sys_clk;

  // Pulse monitor, sampled away from the active edge.
  always @(negedge sys_clk) begin
    if (sample_valid) begin
      vcount++;
      if (prev_valid) wide_pulses++;
    end
    prev_valid = sample_valid;
  end

  task automatic check96(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One bit period: inputs change while the clock is high, sampled on the fall.
  task automatic bit_cycle(input logic mark, input logic [2:0] d);
    frame_mark = mark;
    lane_in    = d;
    #BIT_HALF bit_clk = 1'b0;
    #BIT_HALF bit_clk = 1'b1;
  endtask

  task automatic send_frame(input logic split, input logic [95:0] w,
                            input int nbits, input logic flip);
    split_mode = split;
    for (int i = 0; i < nbits; i++) begin
      logic [2:0] d;
      if (split) begin
        d[0] = w[95 - i];
        d[1] = w[63 - i];
        d[2] = w[31 - i];
      end else begin
        d[0] = w[95 - i];
        d[1] = i[0];
        d[2] = ~i[1];
      end
      bit_cycle(i == 0, d);
      if (flip && i == 0) split_mode = ~split;
    end
    frame_mark = 1'b0;
  endtask

  task automatic apply_reset();
    bit_rst_n = 1'b0;
    sys_rst_n = 1'b0;
    #(CLK_PERIOD*5);
    bit_rst_n = 1'b1;
    sys_rst_n = 1'b1;
    #(CLK_PERIOD*3);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    logic [95:0] last;
    apply_reset();

    // R1: reset state
    check_int("R1 valid after reset", int'(sample_valid), 0);
    check_int("R1 err after reset", int'(frame_err), 0);
    check96("R1 data after reset", sample_data, '0);

    // R2 / R3 / R4: vector table
    foreach (VECS[n]) begin
      base = vcount;
      send_frame(VECS[n].split, VECS[n].word, VECS[n].split ? 32 : 96, 1'b0);
      #SETTLE;
      check_int(VECS[n].split ? "R3 R4 pulse count" : "R2 R4 pulse count", vcount - base, 1);
      check96(VECS[n].split ? "R3 split word" : "R2 serial word", sample_data, VECS[n].word);
    end

    // R5: trailing clocks after a complete frame are ignored
    base = vcount;
    last = sample_data;
    for (int i = 0; i < 12; i++) bit_cycle(1'b0, 3'b101);
    #SETTLE;
    check_int("R5 no pulse from trailing clocks", vcount - base, 0);
    check96("R5 data unchanged", sample_data, last);

    // R7: mode change inside a frame has no effect
    base = vcount;
    send_frame(1'b1, 96'h0BAD_F00D_CAFE_0001_7777_8888, 32, 1'b1);
    #SETTLE;
    check_int("R7 split frame length kept", vcount - base, 1);
    check96("R7 split placement kept", sample_data, 96'h0BAD_F00D_CAFE_0001_7777_8888);
    base = vcount;
    send_frame(1'b0, 96'h1111_2222_3333_4444_5555_6666, 96, 1'b1);
    #SETTLE;
    check_int("R7 serial frame length kept", vcount - base, 1);
    check96("R7 serial placement kept", sample_data, 96'h1111_2222_3333_4444_5555_6666);
    check_int("R6 no error from clean frames", int'(frame_err), 0);

    // R6: early marker restarts capture and sets the flag
    base = vcount;
    send_frame(1'b0, 96'hFFFF_0000_FFFF_0000_FFFF_0000, 20, 1'b0);
    send_frame(1'b0, 96'h0246_8ACE_1357_9BDF_0F0F_F0F0, 96, 1'b0);
    #SETTLE;
    check_int("R6 one pulse after restart", vcount - base, 1);
    check96("R6 restarted word", sample_data, 96'h0246_8ACE_1357_9BDF_0F0F_F0F0);
    check_int("R6 error flag set", int'(frame_err), 1);

    // R6: flag stays set across a later good frame
    send_frame(1'b1, 96'h0000_0001_0000_0002_0000_0003, 32, 1'b0);
    #SETTLE;
    check96("R6 good frame after error", sample_data, 96'h0000_0001_0000_0002_0000_0003);
    check_int("R6 flag sticky", int'(frame_err), 1);

    // R4: no pulse ever longer than one cycle
    check_int("R4 pulse width", wide_pulses, 0);

    // R1: reset clears the flag and the output
    apply_reset();
    check_int("R1 err cleared by reset", int'(frame_err), 0);
    check_int("R1 valid low after reset", int'(sample_valid), 0);
    check96("R1 data cleared by reset", sample_data, '0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule